// File: doc/BRIEF.md
# Multi-Slot Sign-Change Monitor

This block sits beside the result storage of a multi-channel converter and watches every signed result written into one of ten result slots. For each write it compares the sign of the new value with the sign of the value last written to the same slot. When the sign has flipped in a direction the slot is programmed to watch, a sticky status flag for that slot is set. The OR of all flags, gated by a global enable, drives an interrupt line.

Software programs a 2-bit direction field per slot across two control registers. It reads the sticky flags and clears them by writing ones, and it gates the interrupt with an enable bit. The block never alters or stalls the result writes. It only observes them.

Top module: `zero_cross_monitor`

## Requirements
- R1: After a synchronous active-low reset, both control registers, the status register and the interrupt enable read 0, and `irq` is low.
- R2: Register addresses are: 0 holds the fields of slots 0..7, with slot k at bits [2k+1:2k]; 1 holds slot 8 at bits [1:0] and slot 9 at bits [3:2]; 2 is status, with slot k at bit k; 3 is the interrupt enable at bit 0. Unused bits read as 0.
- R3: Field value 01 flags a slot only when the sign goes from non-negative to negative.
- R4: Field value 10 flags a slot only when the sign goes from negative to non-negative.
- R5: Field value 11 flags a sign change in either direction.
- R6: Field value 00 (the reset value) flags nothing for that slot. The stored sign of the slot is still updated by writes made while the field is 00.
- R7: The first write to a slot after reset only records its sign and never flags.
- R8: The sign is the MSB of the result, and zero counts as non-negative. Two samples with the same sign never flag.
- R9: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R10: If a crossing on a slot and a write-one-to-clear of its status bit happen in the same cycle, the bit ends up set.
- R11: `irq` is high exactly when the enable bit is 1 and at least one status bit is set.
- R12: Each slot is compared only with the previous sample of that same slot. Writes to other slots neither flag it nor disturb its stored sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_wr | input | 1 | A result is written this cycle |
| res_slot | input | 4 | Slot index of the written result (0..9) |
| res_data | input | 12 | Signed result value |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Gated crossing interrupt |

## Verification
The checker watches several rules on every cycle:
- the interrupt stays low while the enable is off;
- a status bit never clears except through a write-one-to-clear;
- no status bit becomes set for a slot whose field is 00;
- at most one slot detects a crossing per cycle;
- status and interrupt are clean right after reset.

Only the directed scenarios can show the following:
- each direction code flags exactly the intended transitions;
- zero is treated as non-negative;
- the first sample is ignored;
- a slot keeps tracking its sign while disabled;
- set wins over clear;
- slots stay independent.

// File: rtl/zc_pkg.sv
// Shared constants and types of the sign-change monitor.
// Assumes at most two control registers of eight 2-bit fields each.
package zc_pkg;
    localparam int ZC_FIELD_W       = 2;
    localparam int ZC_REG_W         = 16;
    localparam int ZC_FIELDS_PER_REG = ZC_REG_W / ZC_FIELD_W;
    localparam int ZC_ADDR_W        = 2;

    localparam logic [ZC_ADDR_W-1:0] ZC_ADDR_STATUS = 2'd2;
    localparam logic [ZC_ADDR_W-1:0] ZC_ADDR_IEN    = 2'd3;

    // Direction codes of a per-slot field.
    typedef enum logic [ZC_FIELD_W-1:0] {
        ZC_OFF  = 2'b00,
        ZC_FALL = 2'b01,
        ZC_RISE = 2'b10,
        ZC_BOTH = 2'b11
    } zc_dir_e;
endpackage

// File: rtl/zc_slot_detect.sv
// One slot's sign tracker. It keeps the sign of the last sample written to
// this slot and raises hit_o in the write cycle when the new sign differs
// in the programmed direction. Assumes wr_i is already decoded for this slot.
module zc_slot_detect
    import zc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_i,
    input  logic    sign_i,
    input  zc_dir_e dir_i,
    output logic    hit_o
);
    logic prev_sign_q;
    logic primed_q;
    logic dir_ok;

    // Record the sign of every write, enabled or not.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sign_q <= 1'b0;
            primed_q    <= 1'b0;
        end else if (wr_i) begin
            prev_sign_q <= sign_i;
            primed_q    <= 1'b1;
        end
    end

    // Decide whether this transition matches the selected direction.
    always_comb begin
        unique case (dir_i)
            ZC_FALL: dir_ok = !prev_sign_q && sign_i;
            ZC_RISE: dir_ok = prev_sign_q && !sign_i;
            ZC_BOTH: dir_ok = prev_sign_q != sign_i;
            default: dir_ok = 1'b0;
        endcase
    end

    // A crossing needs a write, a prior sample and a matching direction.
    assign hit_o = wr_i && primed_q && dir_ok;
endmodule

// File: rtl/zc_regs.sv
// Register file of the monitor: the direction fields, the sticky status with
// write-one-to-clear (set wins), the interrupt enable and the read mux.
// Assumes NUM_SLOTS <= 2 * ZC_FIELDS_PER_REG.
module zc_regs
    import zc_pkg::*;
#(
    parameter int NUM_SLOTS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ZC_ADDR_W-1:0] addr,
    input  logic [ZC_REG_W-1:0]  wdata,
    output logic [ZC_REG_W-1:0]  rdata,
    input  logic [NUM_SLOTS-1:0] hit_vec,
    output zc_dir_e              dir_o [NUM_SLOTS],
    output logic [NUM_SLOTS-1:0] status_o,
    output logic [NUM_SLOTS-1:0] clr_mask_o,
    output logic                 ien_o
);
    zc_dir_e              dir_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] status_q;
    logic                 ien_q;

    // Write-one-to-clear mask for the status register.
    assign clr_mask_o = (wr_en && addr == ZC_ADDR_STATUS) ? wdata[NUM_SLOTS-1:0] : '0;

    // Load direction fields from whichever control register holds them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_SLOTS; k++) dir_q[k] <= ZC_OFF;
        end else if (wr_en) begin
            for (int k = 0; k < NUM_SLOTS; k++) begin
                if (addr == ZC_ADDR_W'(k / ZC_FIELDS_PER_REG))
                    dir_q[k] <= zc_dir_e'(wdata[(k % ZC_FIELDS_PER_REG)*ZC_FIELD_W +: ZC_FIELD_W]);
            end
        end
    end

    // Sticky status: new crossings set, ones written clear, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask_o) | hit_vec;
    end

    // Global interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ien_q <= 1'b0;
        else if (wr_en && addr == ZC_ADDR_IEN) ien_q <= wdata[0];
    end

    // Read multiplexer; unused bits return zero.
    always_comb begin
        rdata = '0;
        case (addr)
            ZC_ADDR_STATUS: rdata[NUM_SLOTS-1:0] = status_q;
            ZC_ADDR_IEN:    rdata[0] = ien_q;
            default: begin
                for (int k = 0; k < NUM_SLOTS; k++) begin
                    if (addr == ZC_ADDR_W'(k / ZC_FIELDS_PER_REG))
                        rdata[(k % ZC_FIELDS_PER_REG)*ZC_FIELD_W +: ZC_FIELD_W] = dir_q[k];
                end
            end
        endcase
    end

    assign dir_o    = dir_q;
    assign status_o = status_q;
    assign ien_o    = ien_q;
endmodule

// File: rtl/zero_cross_monitor.sv
// Top of the sign-change monitor. It decodes result writes to per-slot
// trackers, collects their hits into the register file and drives the gated
// interrupt. Assumes at most one result write per cycle.
module zero_cross_monitor
    import zc_pkg::*;
#(
    parameter int NUM_SLOTS = 10,
    parameter int DATA_W    = 12,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 res_wr,
    input  logic [SLOT_W-1:0]    res_slot,
    input  logic [DATA_W-1:0]    res_data,
    input  logic                 reg_wr,
    input  logic [ZC_ADDR_W-1:0] reg_addr,
    input  logic [ZC_REG_W-1:0]  reg_wdata,
    output logic [ZC_REG_W-1:0]  reg_rdata,
    output logic                 irq
);
    zc_dir_e              dir_vec [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] hit_vec;
    logic [NUM_SLOTS-1:0] en_vec;
    logic [NUM_SLOTS-1:0] status_q;
    logic [NUM_SLOTS-1:0] clr_mask;
    logic                 ien_q;
    logic                 sample_sign;

    assign sample_sign = res_data[DATA_W-1];

    // One tracker per slot, each seeing only its own writes.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        zc_slot_detect u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_i   (res_wr && res_slot == SLOT_W'(g)),
            .sign_i (sample_sign),
            .dir_i  (dir_vec[g]),
            .hit_o  (hit_vec[g])
        );
        assign en_vec[g] = dir_vec[g] != ZC_OFF;
    end

    zc_regs #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .hit_vec    (hit_vec),
        .dir_o      (dir_vec),
        .status_o   (status_q),
        .clr_mask_o (clr_mask),
        .ien_o      (ien_q)
    );

    // Interrupt: any pending flag, gated by the enable.
    assign irq = ien_q && (|status_q);
endmodule

// File: rtl/zc_monitor_checker.sv
// Cycle-by-cycle rules of the sign-change monitor, bound into the top.
module zc_monitor_checker #(
    parameter int NUM_SLOTS = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 irq,
    input logic                 ien_q,
    input logic [NUM_SLOTS-1:0] status_q,
    input logic [NUM_SLOTS-1:0] clr_mask,
    input logic [NUM_SLOTS-1:0] en_vec,
    input logic [NUM_SLOTS-1:0] hit_vec
);
    // R1: nothing pending right after reset is released.
    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status_q == '0 && !irq));

    // R6: no status bit newly set for a slot whose field was 00.
    assert_disabled_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(en_vec)) == '0));

    // R9: a set bit only drops when a one was written to it.
    assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_q) & ~$past(clr_mask) & ~status_q) == '0));

    // R11: interrupt held low while the enable is off.
    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_q |-> !irq);

    // R12: a single write can trigger at most one slot.
    assert_one_slot_hit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

bind zero_cross_monitor zc_monitor_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .ien_q    (ien_q),
    .status_q (status_q),
    .clr_mask (clr_mask),
    .en_vec   (en_vec),
    .hit_vec  (hit_vec)
);

// File: tb/zero_cross_monitor_test.sv
module zero_cross_monitor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_wr = 1'b0;
    logic [3:0]  res_slot = '0;
    logic [11:0] res_data = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    localparam logic [11:0] POS = 12'h100;
    localparam logic [11:0] NEG = 12'hF00;

    always #2.5 clk = ~clk;

    zero_cross_monitor uut (
        .clk(clk), .rst_n(rst_n), .res_wr(res_wr), .res_slot(res_slot),
        .res_data(res_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [1:0] a, logic [15:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic push(logic [3:0] s, logic [11:0] d);
        @(negedge clk);
        res_wr = 1'b1; res_slot = s; res_data = d;
        @(negedge clk);
        res_wr = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl0", 2'd0, 16'h0);
        rd_chk("R1 ctrl1", 2'd1, 16'h0);
        rd_chk("R1 status", 2'd2, 16'h0);
        rd_chk("R1 ien", 2'd3, 16'h0);
        chk("R1 irq", {15'd0, irq}, 16'h0);
    endtask

    task automatic t_map;
        wr_reg(2'd0, 16'hE4B1);
        rd_chk("R2 ctrl0 readback", 2'd0, 16'hE4B1);
        wr_reg(2'd1, 16'hFFFF);
        rd_chk("R2 ctrl1 unused bits", 2'd1, 16'h000F);
        wr_reg(2'd3, 16'hFFFF);
        rd_chk("R2 ien unused bits", 2'd3, 16'h0001);
        wr_reg(2'd3, 16'h0000);
        wr_reg(2'd0, 16'hFFFF);
    endtask

    task automatic t_first;
        push(4'd0, NEG);
        rd_chk("R7 first sample no flag", 2'd2, 16'h0);
        push(4'd0, POS);
        rd_chk("R5 both dir rise", 2'd2, 16'h0001);
        wr_reg(2'd2, 16'h0000);
        rd_chk("R9 write zero keeps bit", 2'd2, 16'h0001);
        wr_reg(2'd2, 16'h0001);
        rd_chk("R9 w1c clears", 2'd2, 16'h0);
        push(4'd0, NEG);
        rd_chk("R5 both dir fall", 2'd2, 16'h0001);
        wr_reg(2'd2, 16'h0001);
    endtask

    task automatic t_fall;
        wr_reg(2'd0, 16'hFFF7);   // slot1 = 01
        push(4'd1, POS);
        push(4'd1, NEG);
        rd_chk("R3 fall flagged", 2'd2, 16'h0002);
        wr_reg(2'd2, 16'h0002);
        push(4'd1, POS);
        rd_chk("R3 rise ignored", 2'd2, 16'h0);
    endtask

    task automatic t_rise;
        wr_reg(2'd0, 16'hFFE7);   // slot2 = 10
        push(4'd2, POS);
        push(4'd2, NEG);
        rd_chk("R4 fall ignored", 2'd2, 16'h0);
        push(4'd2, POS);
        rd_chk("R4 rise flagged", 2'd2, 16'h0004);
        wr_reg(2'd2, 16'h0004);
    endtask

    task automatic t_zero;
        push(4'd3, NEG);
        push(4'd3, 12'h000);
        rd_chk("R8 neg to zero is rise", 2'd2, 16'h0008);
        wr_reg(2'd2, 16'h0008);
        push(4'd3, POS);
        rd_chk("R8 zero to pos same sign", 2'd2, 16'h0);
        push(4'd3, 12'h7FF);
        rd_chk("R8 pos to pos same sign", 2'd2, 16'h0);
    endtask

    task automatic t_disabled;
        wr_reg(2'd0, 16'hFCE7);   // slot4 = 00
        push(4'd4, POS);
        push(4'd4, NEG);
        rd_chk("R6 disabled no flag", 2'd2, 16'h0);
        wr_reg(2'd0, 16'hFFE7);
        push(4'd4, NEG);
        rd_chk("R6 sign tracked while off", 2'd2, 16'h0);
        push(4'd4, POS);
        rd_chk("R6 enabled after tracking", 2'd2, 16'h0010);
        wr_reg(2'd2, 16'h0010);
    endtask

    task automatic t_irq;
        push(4'd5, POS);
        push(4'd5, NEG);
        rd_chk("R11 status set", 2'd2, 16'h0020);
        chk("R11 irq gated off", {15'd0, irq}, 16'h0);
        wr_reg(2'd3, 16'h0001);
        chk("R11 irq on", {15'd0, irq}, 16'h0001);
        wr_reg(2'd2, 16'h0020);
        chk("R11 irq drops after clear", {15'd0, irq}, 16'h0);
        wr_reg(2'd3, 16'h0000);
    endtask

    task automatic t_set_wins;
        push(4'd6, POS);
        push(4'd6, NEG);
        rd_chk("R10 pre-set", 2'd2, 16'h0040);
        @(negedge clk);
        res_wr = 1'b1; res_slot = 4'd6; res_data = POS;
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0040;
        @(negedge clk);
        res_wr = 1'b0; reg_wr = 1'b0;
        rd_chk("R10 set beats clear", 2'd2, 16'h0040);
        wr_reg(2'd2, 16'h0040);
        rd_chk("R10 later clear", 2'd2, 16'h0);
    endtask

    task automatic t_indep;
        push(4'd8, POS);
        push(4'd9, NEG);
        push(4'd8, NEG);
        rd_chk("R12 slot8 only", 2'd2, 16'h0100);
        push(4'd9, NEG);
        rd_chk("R12 slot9 kept own sign", 2'd2, 16'h0100);
        push(4'd9, POS);
        rd_chk("R12 slot9 flagged", 2'd2, 16'h0300);
        wr_reg(2'd2, 16'h03FF);
        rd_chk("R12 all cleared", 2'd2, 16'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_map;
        wr_reg(2'd1, 16'h000F);
        t_first;
        t_fall;
        t_rise;
        t_zero;
        t_disabled;
        t_irq;
        t_set_wins;
        t_indep;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule